// File: doc/BRIEF.md
# Two-Cycle Eight-Bit Processor Core

This block is a small 8-bit processor core. It runs programs held in an external read-only instruction store. It has sixteen 8-bit registers. Register 0 is the program counter and drives the instruction address. Register 15 drives an output port at all times. Each instruction takes two clock cycles. In the first cycle the core latches the 16-bit word at the current program counter. In the second cycle it runs one adder operation, makes a conditional register write and advances the counter.

The program counter is an ordinary register. It goes up by one after every instruction, counting from the value written to it when an instruction writes it. Any conditional write of N-1 into register 0 is therefore a branch to N. The datapath is a single add-with-carry. Inverting the B operand, forcing the carry in and replacing the A operand with zero give the other operations: move, subtract, add with carry, increment, decrement and invert.

Top module: `mcore_top`

## Requirements
- R1: A synchronous reset clears all sixteen registers and the Z/N/C flags, and leaves the core in the fetch phase. While reset is high, `mem_addr` and `out_port` read 0.
- R2: Phases alternate from the first edge after reset: fetch, then execute. The fetch edge latches `mem_data` at `mem_addr`. The register write from that word is visible after the following execute edge, and never after the fetch edge.
- R3: `mem_addr` carries register 0 and holds steady from the fetch edge to the execute edge. After an execute that does not write register 0, it is the previous value plus 1, modulo 256.
- R4: An execute that writes value V to register 0 sets the next `mem_addr` to V+1. When register 0 is selected as operand A, it reads the address of the instruction being executed.
- R5: Word bit 15 = 1 is immediate format: bits [11:4] are an 8-bit constant placed on operand B, bits [3:0] name the destination, operand A is zero, no inversion and no carry in, and the flags are not written. Bit 15 = 0 is register format: bits [3:0] name operand A and the destination, [7:4] operand B, bit 8 inverts B, bit 9 forces carry in = 1, bit 10 feeds the C flag to carry in, and bit 11 enables operand A.
- R6: The result is (A or 0) + (B or ~B) + carry-in, modulo 256. Carry-in is the OR of force-carry and (carry-select AND C).
- R7: Register 0 selected as operand B reads as 0.
- R8: Flags are written only by a register-format word with bit 11 = 1. Z = (result == 0), N = result bit 7, C = carry out of bit 7. All other instructions leave the flags unchanged.
- R9: Bits [13:12] pick the write condition: 0 always, 1 Z, 2 N, 3 C. Bit 14 inverts it. The condition is tested on the flags held before the instruction. When it is false, the destination keeps its value, but the flags are still updated as R8 gives.
- R10: `out_port` always equals register 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Instruction address (register 0) |
| mem_data | input | 16 | Instruction word at `mem_addr`, combinational from the store |
| out_port | output | 8 | Register 15 |

## Verification
A word present at `mem_addr` after reset release is latched on the first rising edge. Its register write and the new `mem_addr` both appear after the second edge. Each later instruction adds two more edges. The bench drives and samples on falling edges. The monitor compares `out_port` only when `mem_addr` has just moved to the address queued with the expected value, so each comparison falls in the half cycle after the execute edge of the instruction that produced the value. Reset values and the first instruction's timing are checked edge by edge.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

  localparam int DW = 8;    // datapath width
  localparam int SW = 4;    // register index width
  localparam int IW = 16;   // instruction word width

  typedef enum logic [1:0] {
    CND_ALWAYS = 2'd0,
    CND_ZERO   = 2'd1,
    CND_NEG    = 2'd2,
    CND_CARRY  = 2'd3
  } cond_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
  } flags_t;

  typedef struct packed {
    logic          imm_fmt;
    logic          cnd_inv;
    cond_e         cnd_sel;
    logic          use_a;
    logic          carry_sel;
    logic          carry_one;
    logic          inv_b;
    logic [SW-1:0] b_idx;
    logic [DW-1:0] imm;
    logic [SW-1:0] dst;
  } ctrl_t;

  // condition test against the flags held before the instruction
  function automatic logic cond_holds(input cond_e sel, input logic inv, input flags_t f);
    logic v;
    unique case (sel)
      CND_ALWAYS: v = 1'b1;
      CND_ZERO:   v = f.z;
      CND_NEG:    v = f.n;
      default:    v = f.c;
    endcase
    return v ^ inv;
  endfunction

  // single adder of the core: carry out in the top bit
  function automatic logic [DW:0] add_with_carry(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                                  input logic cin);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  endfunction

  function automatic flags_t flags_of(input logic [DW:0] sum);
    flags_t f;
    f.z = (sum[DW-1:0] == '0);
    f.n = sum[DW-1];
    f.c = sum[DW];
    return f;
  endfunction

endpackage

// File: rtl/mcore_decode.sv
module mcore_decode
  import mcore_pkg::*;
(
  input  logic [IW-1:0] word,
  output ctrl_t         ctl
);

  localparam int BIT_FMT   = IW - 1;
  localparam int BIT_INV   = IW - 2;
  localparam int BIT_CSEL  = IW - 3;
  localparam int BIT_USEA  = 11;
  localparam int BIT_CFLAG = 10;
  localparam int BIT_CONE  = 9;
  localparam int BIT_INVB  = 8;
  localparam int LSB_B     = SW;
  localparam int LSB_IMM   = SW;

  always_comb begin
    ctl.imm_fmt = word[BIT_FMT];
    ctl.cnd_inv = word[BIT_INV];
    ctl.cnd_sel = cond_e'(word[BIT_CSEL -: 2]);
    ctl.dst     = word[SW-1:0];
    ctl.imm     = word[LSB_IMM +: DW];
    if (word[BIT_FMT]) begin
      ctl.use_a     = 1'b0;
      ctl.carry_sel = 1'b0;
      ctl.carry_one = 1'b0;
      ctl.inv_b     = 1'b0;
      ctl.b_idx     = '0;
    end else begin
      ctl.use_a     = word[BIT_USEA];
      ctl.carry_sel = word[BIT_CFLAG];
      ctl.carry_one = word[BIT_CONE];
      ctl.inv_b     = word[BIT_INVB];
      ctl.b_idx     = word[LSB_B +: SW];
    end
  end

endmodule

// File: rtl/mcore_fetch.sv
module mcore_fetch
  import mcore_pkg::*;
#(
  parameter int INSTR_W = IW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] mem_data,
  output logic               exec_now,
  output logic [INSTR_W-1:0] ir
);

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      ir      <= '0;
    end else begin
      phase_q <= (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
      if (phase_q == PH_FETCH) ir <= mem_data;
    end
  end

  assign exec_now = (phase_q == PH_EXEC);

endmodule

// File: rtl/mcore_regs.sv
module mcore_regs #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_step,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  a_idx,
  input  logic [SEL_W-1:0]  b_idx,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val,
  output logic [DATA_W-1:0] pc_val,
  output logic [DATA_W-1:0] out_val
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] rd [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wr_en && (wr_idx == SEL_W'(g));
    if (g == 0) begin : g_pc
      // counter register: advances past the written value or its own
      always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (pc_step) q <= (hit ? wr_data : q) + ONE;
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (hit) q <= wr_data;
      end
    end
    assign rd[g] = q;
  end

  assign a_val   = rd[a_idx];
  assign b_val   = (b_idx == '0) ? '0 : rd[b_idx];
  assign pc_val  = rd[0];
  assign out_val = rd[NUM_REGS-1];

endmodule

// File: rtl/mcore_exec.sv
module mcore_exec
  import mcore_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_now,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              flags_we,
  output flags_t            flags_q
);

  logic [DATA_W-1:0] a_bus, b_src, b_bus;
  logic              cin;
  logic [DATA_W:0]   sum;

  always_comb begin
    a_bus = ctl.use_a ? a_val : '0;
    b_src = ctl.imm_fmt ? ctl.imm : b_val;
    b_bus = ctl.inv_b ? ~b_src : b_src;
    cin   = ctl.carry_one | (ctl.carry_sel & flags_q.c);
    sum   = add_with_carry(a_bus, b_bus, cin);
  end

  assign wr_data  = sum[DATA_W-1:0];
  assign wr_en    = exec_now && cond_holds(ctl.cnd_sel, ctl.cnd_inv, flags_q);
  assign flags_we = exec_now && ctl.use_a;

  always_ff @(posedge clk) begin
    if (rst)           flags_q <= '0;
    else if (flags_we) flags_q <= flags_of(sum);
  end

endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
#(
  parameter int DATA_W   = DW,
  parameter int NUM_REGS = 16,
  parameter int INSTR_W  = IW
) (
  input  logic               clk,
  input  logic               rst,
  output logic [DATA_W-1:0]  mem_addr,
  input  logic [INSTR_W-1:0] mem_data,
  output logic [DATA_W-1:0]  out_port
);

  localparam int SEL_W = $clog2(NUM_REGS);

  logic               exec_now;
  logic [INSTR_W-1:0] ir;
  ctrl_t              ctl;
  logic [DATA_W-1:0]  a_val, b_val, pc_val;
  logic               wr_en, flags_we;
  logic [SEL_W-1:0]   wr_idx;
  logic [DATA_W-1:0]  wr_data;
  flags_t             flags_q;

  mcore_fetch #(.INSTR_W(INSTR_W)) u_fetch (
    .clk(clk), .rst(rst), .mem_data(mem_data), .exec_now(exec_now), .ir(ir)
  );

  mcore_decode u_dec (.word(ir), .ctl(ctl));

  assign wr_idx = ctl.dst;

  mcore_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .pc_step(exec_now),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .a_idx(ctl.dst), .b_idx(ctl.b_idx),
    .a_val(a_val), .b_val(b_val), .pc_val(pc_val), .out_val(out_port)
  );

  mcore_exec #(.DATA_W(DATA_W)) u_exec (
    .clk(clk), .rst(rst), .exec_now(exec_now), .ctl(ctl),
    .a_val(a_val), .b_val(b_val),
    .wr_en(wr_en), .wr_data(wr_data), .flags_we(flags_we), .flags_q(flags_q)
  );

  assign mem_addr = pc_val;

endmodule

// File: rtl/mcore_checker.sv
module mcore_checker
  import mcore_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int SEL_W  = SW
) (
  input logic              clk,
  input logic              rst,
  input logic              exec_now,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              flags_we,
  input flags_t            flags_q,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] out_port
);

  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);
  localparam logic [SEL_W-1:0]  OUT_IX = '1;

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (mem_addr == '0 && out_port == '0 && !exec_now && flags_q == '0));

  assert_fetch_then_exec_R2: assert property (@(posedge clk) disable iff (rst)
    !exec_now |=> exec_now);

  assert_exec_then_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    exec_now |=> !exec_now);

  assert_addr_held_in_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    !exec_now |=> $stable(mem_addr));

  assert_pc_steps_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_now && !(wr_en && wr_idx == '0)) |=> mem_addr == $past(mem_addr) + ONE);

  assert_jump_lands_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_now && wr_en && wr_idx == '0) |=> mem_addr == $past(wr_data) + ONE);

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !flags_we |=> $stable(flags_q));

  assert_out_only_on_write_R10: assert property (@(posedge clk) disable iff (rst)
    !(exec_now && wr_en && wr_idx == OUT_IX) |=> $stable(out_port));

endmodule

bind mcore_top mcore_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .exec_now(exec_now), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_data(wr_data), .flags_we(flags_we), .flags_q(flags_q),
  .mem_addr(mem_addr), .out_port(out_port)
);

// File: tb/test_mcore_top.sv
`timescale 1ns/1ps
module test_mcore_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic [15:0] mem_data;
  logic [7:0]  out_port;

  logic [15:0] rom [256];
  assign mem_data = rom[mem_addr];

  always #2.5 clk = ~clk;   // 200 MHz

  mcore_top i_mcore_top (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_data(mem_data), .out_port(out_port)
  );

  typedef struct {
    int         pc;
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 0;
  logic [7:0] last_pc = 8'h00;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int pc, input logic [7:0] val, input string tag);
    exp_t e;
    e.pc = pc; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: a result is due when the address has just moved to the queued one
  always @(negedge clk) begin
    if (rst) last_pc = 8'h00;
    else if (mem_addr != last_pc) begin
      if (sb.size() > 0 && sb[0].pc == int'(mem_addr)) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, $sformatf("out_port at pc %0d", e.pc), out_port, e.val);
      end
      last_pc = mem_addr;
    end
  end

  task automatic fill_rom(input logic [15:0] word);
    for (int i = 0; i < 256; i++) rom[i] = word;
  endtask

  task automatic hold_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "mem_addr in reset", mem_addr, 0);
    check("R1", "out_port in reset", out_port, 0);
  endtask

  task automatic drain(input string name);
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++; n_bad++;
      $display("FAIL %s %s: actual none expected 0x%0h at pc %0d", e.tag, name, e.val, e.pc);
    end
  endtask

  initial begin
    fill_rom(16'h8BAF);
    rom[0] = 16'h85AF;              // r15 <- 0x5A
    rom[1] = 16'h8F0F;              // r15 <- 0xF0
    hold_reset();
    rst = 1'b0;
    // two-cycle timing of the first instructions
    @(negedge clk);
    check("R2", "out after fetch edge", out_port, 8'h00);
    check("R3", "addr held after fetch edge", mem_addr, 0);
    @(negedge clk);
    check("R2", "out after execute edge", out_port, 8'h5A);
    check("R3", "addr after first instruction", mem_addr, 1);
    @(negedge clk);
    check("R10", "out held during fetch", out_port, 8'h5A);
    @(negedge clk);
    check("R5", "immediate to r15", out_port, 8'hF0);
    check("R3", "addr after second instruction", mem_addr, 2);

    // datapath and condition corner cases
    hold_reset();
    fill_rom(16'h8BAF);
    rom[0]  = 16'h8F01;  rom[1]  = 16'h8102;  rom[2]  = 16'h0821;
    rom[3]  = 16'h0003;  rom[4]  = 16'h0C23;  rom[5]  = 16'h003F;
    rom[6]  = 16'h8053;  rom[7]  = 16'h0B23;  rom[8]  = 16'h003F;
    rom[9]  = 16'hE77F;  rom[10] = 16'hA66F;  rom[11] = 16'h0902;
    rom[12] = 16'h002F;  rom[13] = 16'h0820;  rom[29] = 16'h8EEF;
    rom[30] = 16'h0B22;  rom[31] = 16'h944F;  rom[32] = 16'h81F0;
    push(6,  8'h11, "R6_R7_R8 add-with-carry after move kept C");
    push(9,  8'hF5, "R6 subtract");
    push(10, 8'hF5, "R9 inverted condition false, no write");
    push(11, 8'h66, "R9 negative condition true");
    push(13, 8'h0F, "R7 decrement via zero source");
    push(30, 8'hEE, "R4 relative jump from pc operand");
    push(32, 8'h44, "R9 zero condition");
    rst = 1'b0;
    repeat (200) @(negedge clk);
    drain("corner program");
    check("R4", "self loop address", mem_addr, 32);

    // Fibonacci run, loop exits on carry
    hold_reset();
    fill_rom(16'h8BAF);
    rom[0] = 16'h8001;  rom[1] = 16'h8012;  rom[2]  = 16'h001F;
    rom[3] = 16'h0013;  rom[4] = 16'h0823;  rom[5]  = 16'hB080;
    rom[6] = 16'h0021;  rom[7] = 16'h0032;  rom[8]  = 16'h8010;
    rom[9] = 16'h003F;  rom[10] = 16'h8090;
    begin
      int a = 0, b = 1, t = 0;
      forever begin
        push(3, a[7:0], "R10 fibonacci term");
        t = a + b;
        if (t > 255) break;
        a = b; b = t;
      end
      push(10, t[7:0], "R9 carry exit");
    end
    rst = 1'b0;
    repeat (600) @(negedge clk);
    drain("fibonacci");
    check("R9", "halt loop address", mem_addr, 10);

    hold_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule